// File: doc/BRIEF.md
# Thread Interrupt Presentation Context

This block keeps the interrupt presentation state of one hardware thread. It has two rings: a physical ring, which owns the thread's single notification line, and a pool ring, whose requests are signalled through that same physical notification. Each ring holds four byte fields: a notification code, a current priority, an eight-bit pending-priority buffer and a backlog priority. Priority numbers run from 0, the most favoured, to 7. The value 0xFF means "no priority".

An upstream router sends presentation requests. Each request carries a priority, a ring select and a flag marking it as a group interrupt. The block decides whether the thread is signalled and with which notification code. A group interrupt that the current priority blocks is kept as a backlog priority. It is presented later, when software relaxes the current priority, provided the router still reports the group entry as waiting. Software uses three accesses. A 16-bit acknowledge read takes the most favoured pending interrupt. A byte write sets the current priority. A 32-bit read returns word 0 of either ring.

Top module: `thread_irq_ctx`

## Requirements
- R1: After reset, physical word 0 reads 0x00FF00FF and pool word 0 reads 0x000000FF. Word 0 holds the notification code in bits 31:24, the current priority in bits 23:16, the pending buffer in bits 15:8 and the backlog priority in bits 7:0.
- R2: A direct physical request of priority p sets pending bit 0x80>>p. When p is numerically below the current priority, it also sets the physical notification code to 0x80. Otherwise the code is left unchanged.
- R3: A group physical request whose priority is below the current priority sets the notification code to 0x82 and sets pending bit 0x80>>p.
- R4: A pool request sets bit 0x80>>p in the pool pending buffer and leaves pool code and pool priority at 0. When p is below the physical current priority, it sets the physical notification code to 0x40.
- R5: An acknowledge with a nonzero code returns {code, p} on ack_data. Here p is the lowest-numbered pending bit of the pool buffer when the code is 0x40, and of the physical buffer otherwise. The acknowledge sets the current priority to p, clears the code and clears that bit.
- R6: An acknowledge with code 0 returns {0x00, current priority} and changes no state.
- R7: A group request that is not below the current priority leaves the code and current priority unchanged. The backlog priority becomes the lower of its old value and p.
- R8: A priority write with code 0 and backlog_wait high presents the backlog when the backlog priority is below the new value. Presenting sets code 0x82, sets the backlog's pending bit and resets the backlog to 0xFF. With backlog_wait low, nothing is presented.
- R9: A priority write with code 0 re-presents the lowest pending physical bit with code 0x80 when it is below the new value. This takes precedence over the backlog.
- R10: irq_out is high exactly one cycle after the physical notification code is nonzero.
- R11: At most one operation takes effect per cycle, in the order acknowledge, priority write, presentation. Operations of lower rank in the same cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pres_valid | input | 1 | Presentation request strobe |
| pres_prio | input | PRIO_W | Request priority, 0 most favoured |
| pres_pool | input | 1 | 1 selects the pool ring, 0 the physical ring |
| pres_group | input | 1 | Request is a group interrupt (physical ring) |
| backlog_wait | input | 1 | Router still holds a waiting group backlog entry |
| cppr_wr | input | 1 | Current-priority byte write strobe |
| cppr_data | input | 8 | New current priority |
| ack_strobe | input | 1 | 16-bit acknowledge read strobe |
| ack_data | output | 16 | Acknowledge read data {code, taken priority} |
| rd_pool | input | 1 | Word 0 read select: 1 pool ring, 0 physical ring |
| rd_word0 | output | 32 | Word 0 of the selected ring |
| irq_out | output | 1 | Registered thread notification |

## Verification
The bench builds the block with its default of eight priority levels. With eight levels, the pending buffers fill every bit of their byte, and the bit for priority p sits at 0x80>>p as software sees it. This puts the encoder's choice between several pending bits within reach, as well as the blocked-group backlog, its withdrawal, the precedence of a re-presented direct bit over the backlog, and the same-cycle operation ranking.

// File: rtl/tctx_pkg.sv
// Shared constants and types for the thread interrupt presentation context.
// Assumes byte-wide ring fields and at most eight priority levels.
package tctx_pkg;

    localparam logic [7:0] NSR_NONE  = 8'h00;
    localparam logic [7:0] NSR_PHYS  = 8'h80;
    localparam logic [7:0] NSR_GROUP = 8'h82;
    localparam logic [7:0] NSR_POOL  = 8'h40;
    localparam logic [7:0] PRIO_NONE = 8'hFF;

    typedef struct packed {
        logic [7:0] nsr;
        logic [7:0] cppr;
        logic [7:0] ipb;
        logic [7:0] lsmfb;
    } ring_t;

    // Pending-buffer bit for a priority (zero when out of range).
    function automatic logic [7:0] prio_mask(input logic [7:0] p);
        return 8'h80 >> p;
    endfunction

endpackage

// File: rtl/tctx_prio_enc.sv
// Finds the most favoured (lowest-numbered) pending priority in a buffer.
// Priority p is held in bit 7-p; returns PRIO_NONE when nothing is pending.
module tctx_prio_enc
    import tctx_pkg::*;
#(
    parameter int unsigned NUM_PRIO = 8
) (
    input  logic [7:0] ipb,
    output logic       found,
    output logic [7:0] prio
);

    // Scan from least to most favoured so the lowest number wins.
    always_comb begin
        found = 1'b0;
        prio  = PRIO_NONE;
        for (int p = NUM_PRIO - 1; p >= 0; p--) begin
            if (ipb[7-p]) begin
                found = 1'b1;
                prio  = 8'(p);
            end
        end
    end

endmodule

// File: rtl/tctx_next.sv
// Next-state logic for both rings. Ranks acknowledge over priority write
// over presentation; only the winner acts. Pool code and priority stay 0.
module tctx_next
    import tctx_pkg::*;
#(
    parameter int unsigned NUM_PRIO = 8,
    localparam int unsigned PRIO_W  = $clog2(NUM_PRIO)
) (
    input  ring_t              phys_q,
    input  ring_t              pool_q,
    input  logic               pres_valid,
    input  logic [PRIO_W-1:0]  pres_prio,
    input  logic               pres_pool,
    input  logic               pres_group,
    input  logic               backlog_wait,
    input  logic               cppr_wr,
    input  logic [7:0]         cppr_data,
    input  logic               ack_strobe,
    output ring_t              phys_d,
    output ring_t              pool_d,
    output logic [15:0]        ack_data
);

    logic       phys_found, pool_found;
    logic [7:0] phys_top, pool_top;
    logic [7:0] prio8, taken;
    logic       favoured;

    tctx_prio_enc #(.NUM_PRIO(NUM_PRIO)) u_enc_phys (
        .ipb(phys_q.ipb), .found(phys_found), .prio(phys_top)
    );

    tctx_prio_enc #(.NUM_PRIO(NUM_PRIO)) u_enc_pool (
        .ipb(pool_q.ipb), .found(pool_found), .prio(pool_top)
    );

    assign prio8    = 8'(pres_prio);
    assign favoured = prio8 < phys_q.cppr;

    // Resolve the single operation of this cycle into next ring state.
    always_comb begin
        phys_d   = phys_q;
        pool_d   = pool_q;
        taken    = phys_q.cppr;
        ack_data = {phys_q.nsr, phys_q.cppr};
        if (ack_strobe) begin
            if (phys_q.nsr != NSR_NONE) begin
                if (phys_q.nsr == NSR_POOL) begin
                    taken = pool_top;
                    if (pool_found) pool_d.ipb = pool_q.ipb & ~prio_mask(pool_top);
                end else begin
                    taken = phys_top;
                    if (phys_found) phys_d.ipb = phys_q.ipb & ~prio_mask(phys_top);
                end
                phys_d.cppr = taken;
                phys_d.nsr  = NSR_NONE;
                ack_data    = {phys_q.nsr, taken};
            end
        end else if (cppr_wr) begin
            phys_d.cppr = cppr_data;
            if (phys_q.nsr == NSR_NONE) begin
                if (phys_found && (phys_top < cppr_data)) begin
                    phys_d.nsr = NSR_PHYS;
                end else if (backlog_wait && (phys_q.lsmfb < cppr_data)) begin
                    phys_d.nsr   = NSR_GROUP;
                    phys_d.ipb   = phys_q.ipb | prio_mask(phys_q.lsmfb);
                    phys_d.lsmfb = PRIO_NONE;
                end
            end
        end else if (pres_valid) begin
            if (pres_pool) begin
                pool_d.ipb = pool_q.ipb | prio_mask(prio8);
                if (favoured) phys_d.nsr = NSR_POOL;
            end else if (pres_group) begin
                if (favoured) begin
                    phys_d.nsr = NSR_GROUP;
                    phys_d.ipb = phys_q.ipb | prio_mask(prio8);
                end else if (prio8 < phys_q.lsmfb) begin
                    phys_d.lsmfb = prio8;
                end
            end else begin
                phys_d.ipb = phys_q.ipb | prio_mask(prio8);
                if (favoured) phys_d.nsr = NSR_PHYS;
            end
        end
    end

endmodule

// File: rtl/thread_irq_ctx.sv
// Per-thread interrupt presentation context with a physical and a pool ring.
// Holds ring registers, the registered notification and the word 0 read mux.
// Assumes one software access or one request is meaningful per cycle.
module thread_irq_ctx
    import tctx_pkg::*;
#(
    parameter int unsigned NUM_PRIO = 8,
    localparam int unsigned PRIO_W  = $clog2(NUM_PRIO)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pres_valid,
    input  logic [PRIO_W-1:0] pres_prio,
    input  logic              pres_pool,
    input  logic              pres_group,
    input  logic              backlog_wait,
    input  logic              cppr_wr,
    input  logic [7:0]        cppr_data,
    input  logic              ack_strobe,
    output logic [15:0]       ack_data,
    input  logic              rd_pool,
    output logic [31:0]       rd_word0,
    output logic              irq_out
);

    localparam ring_t PHYS_RESET = '{nsr: NSR_NONE, cppr: PRIO_NONE, ipb: 8'h00, lsmfb: PRIO_NONE};
    localparam ring_t POOL_RESET = '{nsr: NSR_NONE, cppr: 8'h00, ipb: 8'h00, lsmfb: PRIO_NONE};

    ring_t phys_q, pool_q, phys_d, pool_d;
    logic  irq_q;

    tctx_next #(.NUM_PRIO(NUM_PRIO)) u_next (
        .phys_q(phys_q), .pool_q(pool_q),
        .pres_valid(pres_valid), .pres_prio(pres_prio),
        .pres_pool(pres_pool), .pres_group(pres_group),
        .backlog_wait(backlog_wait),
        .cppr_wr(cppr_wr), .cppr_data(cppr_data),
        .ack_strobe(ack_strobe),
        .phys_d(phys_d), .pool_d(pool_d), .ack_data(ack_data)
    );

    // Ring state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_q <= PHYS_RESET;
            pool_q <= POOL_RESET;
        end else begin
            phys_q <= phys_d;
            pool_q <= pool_d;
        end
    end

    // Notification line, one cycle behind the physical code.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (phys_q.nsr != NSR_NONE);
    end

    assign irq_out  = irq_q;
    assign rd_word0 = rd_pool ? pool_q : phys_q;

endmodule

// File: rtl/tctx_checker.sv
// Temporal checks on the presentation context, bound to the top module.
module tctx_checker #(
    parameter int unsigned PRIO_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_strobe,
    input logic              cppr_wr,
    input logic [7:0]        cppr_data,
    input logic              pres_valid,
    input logic              pres_pool,
    input logic              pres_group,
    input logic [PRIO_W-1:0] pres_prio,
    input logic [7:0]        phys_nsr,
    input logic [7:0]        phys_cppr,
    input logic              irq_out
);

    // R10: notification follows the code one cycle later.
    p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == ($past(phys_nsr) != 8'h00)));

    // R5: a serviced acknowledge clears the code.
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_strobe && phys_nsr != 8'h00) |=> (phys_nsr == 8'h00));

    // R6: an acknowledge with nothing signalled leaves priority and code alone.
    p_ack_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_strobe && phys_nsr == 8'h00) |=> ($stable(phys_cppr) && phys_nsr == 8'h00));

    // R11: a write not pre-empted by an acknowledge lands in the priority.
    p_cppr_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cppr_wr && !ack_strobe) |=> (phys_cppr == $past(cppr_data)));

    // R7: a blocked group request changes neither code nor priority.
    p_blocked_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pres_valid && pres_group && !pres_pool && !ack_strobe && !cppr_wr
         && (8'(pres_prio) >= phys_cppr)) |=> ($stable(phys_nsr) && $stable(phys_cppr)));

    // R2: the code only ever holds one of its defined values.
    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_nsr == 8'h00) || (phys_nsr == 8'h80) || (phys_nsr == 8'h82) || (phys_nsr == 8'h40));

endmodule

bind thread_irq_ctx tctx_checker #(.PRIO_W(PRIO_W)) u_tctx_checker (
    .clk(clk), .rst_n(rst_n),
    .ack_strobe(ack_strobe), .cppr_wr(cppr_wr), .cppr_data(cppr_data),
    .pres_valid(pres_valid), .pres_pool(pres_pool), .pres_group(pres_group),
    .pres_prio(pres_prio),
    .phys_nsr(phys_q.nsr), .phys_cppr(phys_q.cppr),
    .irq_out(irq_out)
);

// File: tb/thread_irq_ctx_bench.sv
`timescale 1ns/1ps
module thread_irq_ctx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pres_valid = 0, pres_pool = 0, pres_group = 0, backlog_wait = 0;
    logic [2:0]  pres_prio = '0;
    logic        cppr_wr = 0, ack_strobe = 0, rd_pool = 0;
    logic [7:0]  cppr_data = '0;
    logic [15:0] ack_data;
    logic [31:0] rd_word0;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 word 0, 1 ack data, 2 irq
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;

    thread_irq_ctx u_thread_irq_ctx (
        .clk(clk), .rst_n(rst_n),
        .pres_valid(pres_valid), .pres_prio(pres_prio),
        .pres_pool(pres_pool), .pres_group(pres_group),
        .backlog_wait(backlog_wait),
        .cppr_wr(cppr_wr), .cppr_data(cppr_data),
        .ack_strobe(ack_strobe), .ack_data(ack_data),
        .rd_pool(rd_pool), .rd_word0(rd_word0), .irq_out(irq_out)
    );

    // Monitor: compare outputs against queued expectations mid-cycle.
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
                0:       act = rd_word0;
                1:       act = {16'h0, ack_data};
                default: act = {31'h0, irq_out};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic chk_word(bit pool, logic [31:0] exp, string tag);
        rd_pool = pool;
        push(0, exp, tag);
        step();
    endtask

    task automatic chk_irq(bit exp, string tag);
        push(2, {31'h0, exp}, tag);
        step();
    endtask

    task automatic present(int p, bit pool, bit group);
        pres_valid = 1; pres_prio = 3'(p); pres_pool = pool; pres_group = group;
        step();
        pres_valid = 0; pres_pool = 0; pres_group = 0;
    endtask

    task automatic wr_cppr(logic [7:0] v, bit bw);
        cppr_wr = 1; cppr_data = v; backlog_wait = bw;
        step();
        cppr_wr = 0; backlog_wait = 0;
    endtask

    task automatic ack(logic [15:0] exp, string tag);
        ack_strobe = 1;
        push(1, {16'h0, exp}, tag);
        step();
        ack_strobe = 0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // Driver: stimulus and expected results.
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_word(0, 32'h00FF00FF, "R1 phys reset");
        chk_word(1, 32'h000000FF, "R1 pool reset");
        chk_irq(0, "R1 irq reset");

        // R2 direct presentation, R10 irq lag, R5 acknowledge
        present(5, 0, 0);
        chk_irq(0, "R10 irq not yet");
        chk_irq(1, "R10 irq raised");
        chk_word(0, 32'h80FF04FF, "R2 direct presented");
        ack(16'h8005, "R5 ack direct");
        chk_irq(1, "R10 irq lag on ack");
        chk_irq(0, "R10 irq dropped");
        chk_word(0, 32'h000500FF, "R5 state after ack");
        wr_cppr(8'hFF, 0);
        chk_word(0, 32'h00FF00FF, "R2 idle after reset write");

        // R2 blocked direct, R9 re-presentation on write
        wr_cppr(8'h03, 0);
        present(5, 0, 0);
        chk_word(0, 32'h000304FF, "R2 direct blocked");
        wr_cppr(8'hFF, 0);
        chk_word(0, 32'h80FF04FF, "R9 re-presented");
        ack(16'h8005, "R9 ack re-presented");
        wr_cppr(8'hFF, 0);

        // R5 encoder picks most favoured of several
        present(5, 0, 0);
        present(2, 0, 0);
        chk_word(0, 32'h80FF24FF, "R2 two pending");
        ack(16'h8002, "R5 most favoured first");
        chk_word(0, 32'h000204FF, "R5 bit cleared");
        wr_cppr(8'hFF, 0);
        ack(16'h8005, "R9 second bit");
        wr_cppr(8'hFF, 0);

        // R3 group presentation
        present(6, 0, 1);
        chk_word(0, 32'h82FF02FF, "R3 group presented");
        ack(16'h8206, "R3 ack group");
        wr_cppr(8'hFF, 0);

        // R4 pool presentation
        present(5, 1, 0);
        chk_word(0, 32'h40FF00FF, "R4 phys code for pool");
        chk_word(1, 32'h000004FF, "R4 pool word");
        ack(16'h4005, "R4 ack pool");
        chk_word(1, 32'h000000FF, "R5 pool bit cleared");
        chk_word(0, 32'h000500FF, "R5 phys after pool ack");
        wr_cppr(8'hFF, 0);
        chk_word(0, 32'h00FF00FF, "R4 idle");

        // R7 backlog records most favoured, R8 backlog presented
        wr_cppr(8'h02, 0);
        present(4, 0, 1);
        present(3, 0, 1);
        chk_word(0, 32'h00020003, "R7 backlog held");
        chk_irq(0, "R7 no irq");
        wr_cppr(8'h04, 1);
        chk_word(0, 32'h820410FF, "R8 backlog presented");
        ack(16'h8203, "R8 ack backlog");
        chk_word(0, 32'h000300FF, "R8 after ack");
        wr_cppr(8'hFF, 1);
        chk_word(0, 32'h00FF00FF, "R8 clean after service");

        // R8 withdrawn backlog
        wr_cppr(8'h02, 0);
        present(3, 0, 1);
        wr_cppr(8'h04, 0);
        chk_word(0, 32'h00040003, "R8 withdrawn not presented");
        wr_cppr(8'hFF, 1);
        chk_word(0, 32'h82FF10FF, "R8 late presentation");
        ack(16'h8203, "R8 ack late");
        wr_cppr(8'hFF, 0);

        // R9 direct bit wins over backlog
        wr_cppr(8'h02, 0);
        present(4, 0, 1);
        present(3, 0, 0);
        wr_cppr(8'hFF, 1);
        chk_word(0, 32'h80FF1004, "R9 direct over backlog");
        ack(16'h8003, "R9 ack direct");
        wr_cppr(8'hFF, 1);
        chk_word(0, 32'h82FF08FF, "R9 backlog next");
        ack(16'h8204, "R9 ack backlog");
        wr_cppr(8'hFF, 0);

        // R6 idle acknowledge, R11 ranking
        ack_strobe = 1; cppr_wr = 1; cppr_data = 8'h10;
        pres_valid = 1; pres_prio = 3'd2;
        push(1, 32'h000000FF, "R6 idle ack data");
        step();
        ack_strobe = 0; cppr_wr = 0; pres_valid = 0;
        chk_word(0, 32'h00FF00FF, "R11 write and request dropped");
        cppr_wr = 1; cppr_data = 8'h03; pres_valid = 1; pres_prio = 3'd1;
        step();
        cppr_wr = 0; pres_valid = 0;
        chk_word(0, 32'h000300FF, "R11 request dropped by write");
        wr_cppr(8'hFF, 0);
        chk_word(0, 32'h00FF00FF, "R11 final idle");

        done = 1;
        summary();
        $finish;
    end

endmodule